// File: doc/BRIEF.md
# Sensor Register File With Auto-Increment

This block holds the byte-addressed register map of a three-axis motion sensor and serves it to a host through a byte-level port. The port has three strobes. The address-load strobe sets an internal pointer from the data byte. The write strobe stores a byte at the pointer. With the read strobe, the host takes the byte the block presents at the pointer. Each data byte moves the pointer on, so a host can stream through the sample bytes in one burst. The serial framing of the bus sits outside this block. It also decodes the block's 7-bit bus address from a strap input.

The three 12-bit axis samples arrive on a parallel input with a valid strobe. They appear as pairs of two's-complement bytes, left-justified. A fast-read mode makes the pointer skip the low bytes. The main control register is locked against changes while the sensor is active, except for its mode bit. A self-clearing reset bit returns the whole map to its defaults. New sample sets are held back while a read burst is running, so one burst never mixes two sets.

Top module: `sens_regfile`

## Requirements
- R1: `bus_addr_o` is 7'h1C when `addr_sel_i` is 0 and 7'h1D when it is 1.
- R2: The sample bytes sit at 0x01..0x06 in X, Y, Z order, high byte first. The high byte holds sample bits 11:4. The low byte holds bits 3:0 in bits 7:4, with bits 3:0 zero.
- R3: After address-load, each read or write strobe moves the pointer on by one. The pointer goes from the last address, 0x2B, back to 0x00. A read returns the byte at the pointer in the same cycle as the strobe.
- R4: When the fast-read bit (bit 1 of 0x2A) is 1, the pointer goes 0x01 to 0x03, then 0x03 to 0x05, then 0x05 to 0x07.
- R5: While the mode bit (bit 0 of 0x2A) is 1, a write to 0x2A changes only bit 0. While the mode bit is 0, the write stores the whole byte.
- R6: Writing a byte with bit 6 set to 0x2B returns every register to its default: the control registers, the samples and the status all go to 0x00, and the pointer goes to 0x00. Afterwards 0x2B reads 0x00.
- R7: 0x0D reads the identity value 0x2A. Writes to 0x0D and to 0x00..0x06 are dropped. Unused addresses up to 0x2B read 0x00.
- R8: A sample set that arrives after a read strobe and before the next address-load is not visible until that address-load. After the address-load it becomes visible within two cycles.
- R9: Status bit 3 (0x00) is set when a new sample set becomes visible. A read of any sample byte clears it.
- R10: After `rst_ni` the pointer is 0x00, and the status, sample and control bytes all read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_sel_i | input | 1 | Strap that picks the low bit of the bus address |
| bus_addr_o | output | 7 | Decoded 7-bit bus address |
| addr_load_i | input | 1 | Load pointer from `wdata_i` |
| wr_i | input | 1 | Write `wdata_i` at pointer, then advance |
| rd_i | input | 1 | Read strobe; advance pointer after this byte |
| wdata_i | input | 8 | Address or write data byte |
| rdata_o | output | 8 | Byte at the current pointer |
| smp_valid_i | input | 1 | New sample set present |
| smp_x_i | input | SAMPLE_W | X sample, two's complement |
| smp_y_i | input | SAMPLE_W | Y sample, two's complement |
| smp_z_i | input | SAMPLE_W | Z sample, two's complement |

## Verification
`rdata_o` is combinational from the pointer, so the bench takes each read byte 1 ns after the falling edge of the strobe cycle, before the pointer moves. Pointer, control-register and reset effects take hold at the next rising edge. The bench looks at them through a read that begins at least one full cycle later. A sample set becomes visible two edges after its valid strobe if no burst holds it back. The bench waits three cycles after each sample push before it reads, and checks the coherence rule by reading old bytes across a push in the middle of a burst.

// File: rtl/sens_regfile_pkg.sv
package sens_regfile_pkg;
  localparam int BYTE_W   = 8;
  localparam int AXES     = 3;
  localparam int SMP_BYTES = 2 * AXES;

  localparam logic [7:0] A_STATUS = 8'h00;
  localparam logic [7:0] A_SMP_LO = 8'h01;
  localparam logic [7:0] A_SMP_HI = 8'h06;
  localparam logic [7:0] A_ID     = 8'h0D;
  localparam logic [7:0] A_CTRL1  = 8'h2A;
  localparam logic [7:0] A_CTRL2  = 8'h2B;

  localparam int MODE_BIT = 0;
  localparam int FAST_BIT = 1;
  localparam int SRST_BIT = 6;
  localparam int RDY_BIT  = 3;

  // fast mode hops over low sample bytes
  function automatic logic [7:0] ptr_next(input logic [7:0] p, input logic fast,
                                          input logic [7:0] last);
    if (p >= last) return 8'h00;
    if (fast && (p == 8'h01 || p == 8'h03 || p == 8'h05)) return p + 8'd2;
    return p + 8'd1;
  endfunction
endpackage

// File: rtl/sens_ptr.sv
module sens_ptr #(
  parameter logic [7:0] LAST_ADDR = 8'h2B
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  input  logic       step_i,
  input  logic       clear_i,
  input  logic       fast_i,
  output logic [7:0] ptr_o
);
  import sens_regfile_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_o <= 8'h00;
    else if (load_i)  ptr_o <= load_val_i;
    else if (clear_i) ptr_o <= 8'h00;
    else if (step_i)  ptr_o <= ptr_next(ptr_o, fast_i, LAST_ADDR);
  end
endmodule

// File: rtl/sens_ctrl_regs.sv
module sens_ctrl_regs (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] ptr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] ctrl1_o,
  output logic [7:0] ctrl2_o,
  output logic       srst_o
);
  import sens_regfile_pkg::*;

  assign srst_o = wr_i && (ptr_i == A_CTRL2) && wdata_i[SRST_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl1_o <= 8'h00;
      ctrl2_o <= 8'h00;
    end else if (srst_o) begin
      ctrl1_o <= 8'h00;
      ctrl2_o <= 8'h00;
    end else if (wr_i) begin
      if (ptr_i == A_CTRL1) begin
        if (ctrl1_o[MODE_BIT]) ctrl1_o[MODE_BIT] <= wdata_i[MODE_BIT];
        else                   ctrl1_o <= wdata_i;
      end
      if (ptr_i == A_CTRL2) ctrl2_o <= wdata_i;
    end
  end
endmodule

// File: rtl/sens_sample_bank.sv
module sens_sample_bank #(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                srst_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] x_i,
  input  logic [SAMPLE_W-1:0] y_i,
  input  logic [SAMPLE_W-1:0] z_i,
  input  logic                rd_i,
  input  logic                unlock_i,
  input  logic                rd_smp_i,
  output logic [5:0][7:0]     bytes_o,
  output logic                ready_o,
  output logic                lock_o
);
  localparam int LOW_W = SAMPLE_W - 8;

  logic [2:0][SAMPLE_W-1:0] pend_q, vis_q, smp_in;
  logic                     pend_v_q;
  logic                     apply;

  assign smp_in = {z_i, y_i, x_i};
  // hold back while a burst is open, including its first strobe
  assign apply  = pend_v_q && !lock_o && !rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      vis_q    <= '0;
      pend_v_q <= 1'b0;
      lock_o   <= 1'b0;
      ready_o  <= 1'b0;
    end else if (srst_i) begin
      pend_q   <= '0;
      vis_q    <= '0;
      pend_v_q <= 1'b0;
      lock_o   <= 1'b0;
      ready_o  <= 1'b0;
    end else begin
      if (unlock_i)  lock_o <= 1'b0;
      else if (rd_i) lock_o <= 1'b1;
      if (valid_i) begin
        pend_q   <= smp_in;
        pend_v_q <= 1'b1;
      end else if (apply) begin
        pend_v_q <= 1'b0;
      end
      if (apply) begin
        vis_q   <= pend_q;
        ready_o <= 1'b1;
      end else if (rd_smp_i) begin
        ready_o <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_axis
    assign bytes_o[2*g]   = vis_q[g][SAMPLE_W-1 -: 8];
    assign bytes_o[2*g+1] = 8'(vis_q[g][LOW_W-1:0]) << (8 - LOW_W);
  end
endmodule

// File: rtl/sens_regfile.sv
module sens_regfile #(
  parameter int         SAMPLE_W  = 12,
  parameter logic [6:0] BASE_ADDR = 7'h1C,
  parameter logic [7:0] ID_VALUE  = 8'h2A,
  parameter logic [7:0] LAST_ADDR = 8'h2B
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                addr_sel_i,
  output logic [6:0]          bus_addr_o,
  input  logic                addr_load_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [7:0]          wdata_i,
  output logic [7:0]          rdata_o,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_x_i,
  input  logic [SAMPLE_W-1:0] smp_y_i,
  input  logic [SAMPLE_W-1:0] smp_z_i
);
  import sens_regfile_pkg::*;

  logic [7:0]      ptr_q, ctrl1_q, ctrl2_q;
  logic            wr_en, rd_en, srst, rd_smp, smp_ready, smp_lock;
  logic [5:0][7:0] smp_bytes;

  assign bus_addr_o = {BASE_ADDR[6:1], addr_sel_i};
  assign wr_en      = wr_i && !addr_load_i;
  assign rd_en      = rd_i && !addr_load_i;
  assign rd_smp     = rd_en && (ptr_q >= A_SMP_LO) && (ptr_q <= A_SMP_HI);

  sens_ptr #(.LAST_ADDR(LAST_ADDR)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (addr_load_i),
    .load_val_i (wdata_i),
    .step_i     (wr_en || rd_en),
    .clear_i    (srst),
    .fast_i     (ctrl1_q[FAST_BIT]),
    .ptr_o      (ptr_q)
  );

  sens_ctrl_regs u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en),
    .ptr_i   (ptr_q),
    .wdata_i (wdata_i),
    .ctrl1_o (ctrl1_q),
    .ctrl2_o (ctrl2_q),
    .srst_o  (srst)
  );

  sens_sample_bank #(.SAMPLE_W(SAMPLE_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .srst_i   (srst),
    .valid_i  (smp_valid_i),
    .x_i      (smp_x_i),
    .y_i      (smp_y_i),
    .z_i      (smp_z_i),
    .rd_i     (rd_en),
    .unlock_i (addr_load_i),
    .rd_smp_i (rd_smp),
    .bytes_o  (smp_bytes),
    .ready_o  (smp_ready),
    .lock_o   (smp_lock)
  );

  always_comb begin
    rdata_o = 8'h00;
    if (ptr_q == A_STATUS) rdata_o[RDY_BIT] = smp_ready;
    for (int i = 0; i < SMP_BYTES; i++)
      if (ptr_q == 8'(i + 1)) rdata_o = smp_bytes[i];
    if (ptr_q == A_ID)    rdata_o = ID_VALUE;
    if (ptr_q == A_CTRL1) rdata_o = ctrl1_q;
    if (ptr_q == A_CTRL2) rdata_o = ctrl2_q;
  end
endmodule

// File: rtl/sens_regfile_chk.sv
module sens_regfile_chk #(
  parameter logic [7:0] LAST_ADDR = 8'h2B,
  parameter logic [7:0] ID_VALUE  = 8'h2A
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            addr_load_i,
  input logic            wr_i,
  input logic            rd_i,
  input logic            wsrst_i,
  input logic [7:0]      ptr_i,
  input logic [7:0]      ctrl1_i,
  input logic [7:0]      ctrl2_i,
  input logic            lock_i,
  input logic [5:0][7:0] vis_i,
  input logic [7:0]      rdata_i
);
  import sens_regfile_pkg::*;

  logic step, srst_req;
  assign step     = (rd_i || wr_i) && !addr_load_i;
  assign srst_req = wr_i && !addr_load_i && (ptr_i == A_CTRL2) && wsrst_i;

  p_ptr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !srst_req && !ctrl1_i[FAST_BIT] && ptr_i < LAST_ADDR) |=> ptr_i == $past(ptr_i) + 8'd1);

  p_ptr_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !srst_req && ptr_i == LAST_ADDR) |=> ptr_i == 8'h00);

  p_fast_skip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && ctrl1_i[FAST_BIT] && ptr_i == 8'h03) |=> ptr_i == 8'h05);

  p_ctrl1_guard_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_load_i && ptr_i == A_CTRL1 && ctrl1_i[MODE_BIT]) |=> ctrl1_i[7:1] == $past(ctrl1_i[7:1]));

  p_soft_reset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_req |=> (ctrl1_i == 8'h00 && ctrl2_i == 8'h00 && ptr_i == 8'h00));

  p_id_value_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_i == A_ID) |-> rdata_i == ID_VALUE);

  p_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lock_i || (rd_i && !addr_load_i)) && !srst_req) |=> $stable(vis_i));
endmodule

bind sens_regfile sens_regfile_chk #(.LAST_ADDR(LAST_ADDR), .ID_VALUE(ID_VALUE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_load_i (addr_load_i),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .wsrst_i     (wdata_i[6]),
  .ptr_i       (ptr_q),
  .ctrl1_i     (ctrl1_q),
  .ctrl2_i     (ctrl2_q),
  .lock_i      (smp_lock),
  .vis_i       (smp_bytes),
  .rdata_i     (rdata_o)
);

// File: tb/sens_regfile_test.sv
module sens_regfile_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        addr_sel_i = 1'b0;
  logic [6:0]  bus_addr_o;
  logic        addr_load_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0]  wdata_i = 8'h00;
  logic [7:0]  rdata_o;
  logic        smp_valid_i = 1'b0;
  logic [11:0] smp_x_i = '0, smp_y_i = '0, smp_z_i = '0;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0] v;

  sens_regfile uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // {address, expected byte} after sample X=ABC Y=123 Z=80F
  localparam logic [15:0] VEC [11] = '{
    16'h00_08, 16'h0D_2A, 16'h01_AB, 16'h02_C0, 16'h03_12, 16'h04_30,
    16'h05_80, 16'h06_F0, 16'h07_00, 16'h2A_00, 16'h2B_00};

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic load(input logic [7:0] a);
    @(negedge clk_i); addr_load_i = 1'b1; wdata_i = a;
    @(negedge clk_i); addr_load_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk_i); wr_i = 1'b1; wdata_i = d;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk_i); rd_i = 1'b1; #1 d = rdata_o;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic push(input logic [11:0] x, input logic [11:0] y, input logic [11:0] z);
    @(negedge clk_i); smp_valid_i = 1'b1; smp_x_i = x; smp_y_i = y; smp_z_i = z;
    @(negedge clk_i); smp_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R10 reset state, pointer at 0x00
    rd(v); check("R10 status", v, 8'h00);
    rd(v); check("R10 x_hi", v, 8'h00);
    load(8'h2A); rd(v); check("R10 ctrl1", v, 8'h00);
    // R1
    #1 check("R1 sel0", {1'b0, bus_addr_o}, 8'h1C);
    addr_sel_i = 1'b1; #1 check("R1 sel1", {1'b0, bus_addr_o}, 8'h1D);

    push(12'hABC, 12'h123, 12'h80F);
    // R2 R7 R9 table walk
    for (int i = 0; i < 11; i++) begin
      load(VEC[i][15:8]); rd(v);
      check($sformatf("R2/R7/R9 addr %h", VEC[i][15:8]), v, VEC[i][7:0]);
    end

    // R3 burst from 0x01
    load(8'h01);
    rd(v); check("R3 b0", v, 8'hAB);
    rd(v); check("R3 b1", v, 8'hC0);
    rd(v); check("R3 b2", v, 8'h12);
    rd(v); check("R3 b3", v, 8'h30);
    // R3 wrap
    load(8'h2B); rd(v); check("R3 wrap last", v, 8'h00);
    rd(v); check("R3 wrap status", v, 8'h00);
    rd(v); check("R3 wrap x_hi", v, 8'hAB);
    // R3 writes advance, R5 standby write
    load(8'h2A); wr(8'h02); wr(8'h05);
    load(8'h2A); rd(v); check("R5 standby ctrl1", v, 8'h02);
    rd(v); check("R3 write advance ctrl2", v, 8'h05);

    // R4 fast read
    load(8'h01);
    rd(v); check("R4 x_hi", v, 8'hAB);
    rd(v); check("R4 y_hi", v, 8'h12);
    rd(v); check("R4 z_hi", v, 8'h80);
    rd(v); check("R4 after z", v, 8'h00);

    // R5 guard
    load(8'h2A); wr(8'h03);
    load(8'h2A); wr(8'hF0);
    load(8'h2A); rd(v); check("R5 active guard", v, 8'h02);
    load(8'h2A); wr(8'hF0);
    load(8'h2A); rd(v); check("R5 standby full", v, 8'hF0);
    load(8'h2A); wr(8'h00);

    // R7 read-only drops
    load(8'h0D); wr(8'h55);
    load(8'h0D); rd(v); check("R7 id kept", v, 8'h2A);
    load(8'h01); wr(8'h00);
    load(8'h01); rd(v); check("R7 sample kept", v, 8'hAB);

    // R8 coherence across a push in mid-burst
    load(8'h01); rd(v); check("R8 old x_hi", v, 8'hAB);
    push(12'h456, 12'h789, 12'h7FF);
    rd(v); check("R8 old x_lo", v, 8'hC0);
    rd(v); check("R8 old y_hi", v, 8'h12);
    load(8'h00); repeat (3) @(negedge clk_i);
    rd(v); check("R9 ready set", v, 8'h08);
    rd(v); check("R8 new x_hi", v, 8'h45);
    rd(v); check("R8 new x_lo", v, 8'h60);
    load(8'h05); rd(v); check("R2 new z_hi", v, 8'h7F);
    load(8'h00); rd(v); check("R9 ready cleared", v, 8'h00);

    // R6 soft reset
    load(8'h2A); wr(8'h10);
    load(8'h2B); wr(8'h41);
    load(8'h2B); rd(v); check("R6 ctrl2", v, 8'h00);
    load(8'h2A); rd(v); check("R6 ctrl1", v, 8'h00);
    load(8'h01); rd(v); check("R6 sample", v, 8'h00);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule